// File: doc/BRIEF.md
# Vertical Blank Interrupt Controller

This block drives the one level-sensitive interrupt line of a display controller. Two sources feed it. The first is a vertical-blank source that follows a three-valued tracker. The tracker can be disarmed, armed and idle, or pending. A vblank-start pulse moves it to pending. Writes to a display-timing register can disarm it or re-arm it.

The second source is a group of accelerator status bits. Engine completion pulses set these bits, a control mask selects which of them can interrupt, and a write-ones-to-clear port clears them. A global enable bit in a second display-timing register gates both sources. A separate mask bit suppresses the vblank source only.

Software reads the pending vblank state back through bit 7 of an input-status byte. Video timing itself is generated elsewhere. This block only receives the vblank-start pulse.

Top module: `vblank_irq_ctrl`

## Requirements
- R1: After reset the interrupt line is low, all status bits are zero, the input-status byte is zero, and the vblank tracker is armed-idle. Both display-timing registers, and the control mask, reset to zero.
- R2: A vblank-start pulse moves an armed-idle or pending tracker to pending. From the next cycle, bit 7 of the input-status byte reads 1, and it stays 1 for as long as the tracker is pending.
- R3: A vblank-start pulse leaves a disarmed tracker disarmed.
- R4: A write to mode register index 0x11 with data bit 4 at 0 moves a pending tracker to disarmed. A write to that index with bit 4 at 1 moves a disarmed tracker to armed-idle. Every other combination leaves the tracker unchanged, so an armed-idle tracker written with bit 4 at 0 stays armed.
- R5: The vblank source is active only when all three hold: bit 4 of gate register index 0x32 is 1, bit 5 of register 0x11 is 0, and the tracker is pending.
- R6: Each engine completion pulse sets its own status bit. `eng_done[0]` (FIFO empty) sets bit 2. `eng_done[1]` (3D FIFO empty) sets bit 6. `eng_done[2]` (3D done) sets bit 1.
- R7: The status source is active when the control mask ANDed with the status bits is nonzero and bit 4 of register 0x32 is 1. The interrupt line is the OR of the status source and the vblank source.
- R8: Writing to the clear port clears every status bit whose data bit is 1. If a completion pulse sets a bit in the same cycle that a clear targets it, the set wins.
- R9: The interrupt line is registered. It changes at the first clock edge after the input that causes the change, and it does not change before that edge. A cycle that has only engine completion pulses never lowers the line.
- R10: When a write to register 0x11 and a vblank-start pulse arrive in the same cycle, the write is applied first and the pulse is applied to the result.
- R11: A write to any register index other than 0x11 and 0x32 has no effect on the tracker or on the interrupt line.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| vblank_start | input | 1 | One-cycle pulse at the start of vertical blank |
| crtc_we | input | 1 | Display-timing register write strobe |
| crtc_idx | input | 8 | Register index of the write |
| crtc_wdata | input | 8 | Register write data |
| ctl_we | input | 1 | Control mask write strobe |
| ctl_wdata | input | 8 | New control mask |
| clr_we | input | 1 | Status clear strobe |
| clr_wdata | input | 8 | Status bits to clear (ones clear) |
| eng_done | input | 3 | Completion pulses: FIFO empty, 3D FIFO empty, 3D done |
| irq | output | 1 | Interrupt line, active high |
| stat | output | 8 | Current status bits |
| sense_rd | output | 8 | Input-status byte; bit 7 is vblank pending |

## Verification
A wrong tracker state appears at bit 7 of `sense_rd` one cycle after the pulse or write that produced it. When the gate is enabled and bit 5 is clear, the same error also appears at `irq` in that cycle. A tracker that is wrongly disarmed is easy to miss at first. It shows only at the next vblank pulse, which then fails to raise the line, so the sequences re-arm the tracker and pulse it again. Mask or gate errors show at `irq` one cycle after the write that exposes them. Errors in status set or clear also show at `stat` in that same cycle.

// File: rtl/vblank_irq_ctrl.sv
module vblank_irq_ctrl #(
  parameter int STAT_W = 8,
  parameter int REG_W = 8,
  parameter logic [REG_W-1:0] IDX_MODE = 8'h11,
  parameter logic [REG_W-1:0] IDX_GATE = 8'h32,
  parameter int FIFO_EMPTY_BIT = 2,
  parameter int FIFO3D_EMPTY_BIT = 6,
  parameter int DONE3D_BIT = 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              vblank_start,
  input  logic              crtc_we,
  input  logic [REG_W-1:0]  crtc_idx,
  input  logic [REG_W-1:0]  crtc_wdata,
  input  logic              ctl_we,
  input  logic [STAT_W-1:0] ctl_wdata,
  input  logic              clr_we,
  input  logic [STAT_W-1:0] clr_wdata,
  input  logic [2:0]        eng_done,
  output logic              irq,
  output logic [STAT_W-1:0] stat,
  output logic [7:0]        sense_rd
);
  localparam int GATE_BIT = 4;
  localparam int ARM_BIT  = 4;
  localparam int MASK_BIT = 5;

  typedef enum logic [1:0] {VB_OFF = 2'd0, VB_IDLE = 2'd1, VB_PEND = 2'd2} vb_e;

  vb_e vb_q, vb_n;
  logic [REG_W-1:0]  mode_q, gate_q, mode_n, gate_n;
  logic [STAT_W-1:0] ctl_q, ctl_n, stat_n, eng_bits;
  logic irq_n;

  wire wr_mode = crtc_we && (crtc_idx == IDX_MODE);
  wire wr_gate = crtc_we && (crtc_idx == IDX_GATE);

  assign mode_n = wr_mode ? crtc_wdata : mode_q;
  assign gate_n = wr_gate ? crtc_wdata : gate_q;
  assign ctl_n  = ctl_we ? ctl_wdata : ctl_q;

  always_comb begin
    eng_bits = '0;
    eng_bits[FIFO_EMPTY_BIT]   = eng_done[0];
    eng_bits[FIFO3D_EMPTY_BIT] = eng_done[1];
    eng_bits[DONE3D_BIT]       = eng_done[2];
  end

  assign stat_n = (stat & ~(clr_we ? clr_wdata : '0)) | eng_bits;

  always_comb begin
    vb_n = vb_q;
    if (wr_mode) begin
      if (!crtc_wdata[ARM_BIT] && vb_q == VB_PEND) vb_n = VB_OFF;
      else if (crtc_wdata[ARM_BIT] && vb_q == VB_OFF) vb_n = VB_IDLE;
    end
    if (vblank_start && vb_n != VB_OFF) vb_n = VB_PEND;
  end

  assign irq_n = gate_n[GATE_BIT] &&
                 ((|(ctl_n & stat_n)) || (!mode_n[MASK_BIT] && vb_n == VB_PEND));

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      vb_q   <= VB_IDLE;
      mode_q <= '0;
      gate_q <= '0;
      ctl_q  <= '0;
      stat   <= '0;
      irq    <= 1'b0;
    end else begin
      vb_q   <= vb_n;
      mode_q <= mode_n;
      gate_q <= gate_n;
      ctl_q  <= ctl_n;
      stat   <= stat_n;
      irq    <= irq_n;
    end
  end

  assign sense_rd = {vb_q == VB_PEND, 7'b0};

  assert_off_holds_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (vb_q == VB_OFF && vblank_start && !crtc_we) |=> (vb_q == VB_OFF));

  assert_pend_from_pulse_R2: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(vb_q == VB_PEND) |-> $past(vblank_start));

  assert_idle_to_pend_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (vb_q == VB_IDLE && vblank_start && !crtc_we) |=> (vb_q == VB_PEND));

  assert_engine_no_drop_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (irq && (|eng_done) && !vblank_start && !crtc_we && !ctl_we && !clr_we) |=> irq);

  assert_clear_done_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (clr_we && eng_done == 3'b000) |=> ((stat & $past(clr_wdata)) == '0));

  assert_gate_needed_R7: assert property (@(posedge clk) disable iff (!rst_n)
    irq |-> gate_q[GATE_BIT]);
endmodule

// File: tb/vblank_irq_ctrl_test.sv
module vblank_irq_ctrl_test;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic vblank_start = 1'b0, crtc_we = 1'b0, ctl_we = 1'b0, clr_we = 1'b0;
  logic [7:0] crtc_idx = '0, crtc_wdata = '0, ctl_wdata = '0, clr_wdata = '0;
  logic [2:0] eng_done = '0;
  logic irq;
  logic [7:0] stat, sense_rd;
  int tests = 0, fails = 0;

  always #2.5 clk = ~clk;

  vblank_irq_ctrl uut (
    .clk(clk), .rst_n(rst_n), .vblank_start(vblank_start),
    .crtc_we(crtc_we), .crtc_idx(crtc_idx), .crtc_wdata(crtc_wdata),
    .ctl_we(ctl_we), .ctl_wdata(ctl_wdata), .clr_we(clr_we), .clr_wdata(clr_wdata),
    .eng_done(eng_done), .irq(irq), .stat(stat), .sense_rd(sense_rd)
  );

  // Row format: op, index, data, 0, expected irq, expected pending bit
  // op 0 vblank, 1 register write, 2 control mask, 3 clear, 4 engine pulses
  localparam int NV = 24;
  localparam logic [31:0] VEC [NV] = '{
    32'h1_32_10_000,  // R7 gate on
    32'h0_00_00_011,  // R2 R5 idle -> pending
    32'h1_11_20_000,  // R4 pending -> disarmed
    32'h0_00_00_000,  // R3 disarmed ignores vblank
    32'h1_11_10_000,  // R4 disarmed -> idle
    32'h0_00_00_011,  // R2
    32'h1_11_30_001,  // R5 bit 5 masks vblank source
    32'h1_11_10_011,  // R5
    32'h1_32_00_001,  // R5 gate off
    32'h1_11_00_000,  // R4
    32'h1_32_10_000,  // R7
    32'h2_00_04_000,  // R7
    32'h4_00_01_010,  // R6 fifo empty, bit 2
    32'h3_00_04_000,  // R8
    32'h4_00_02_000,  // R6 3d fifo, bit 6, masked off
    32'h2_00_40_010,  // R7
    32'h1_32_00_000,  // R7
    32'h1_32_10_010,  // R7
    32'h3_00_40_000,  // R8
    32'h1_12_ff_000,  // R11 other index
    32'h0_00_00_000,  // R3
    32'h1_11_10_000,  // R4
    32'h1_11_00_000,  // R4 idle stays armed
    32'h0_00_00_011   // R2
  };

  function automatic string tag_of(input logic [3:0] op);
    case (op)
      4'd0: return "R2/R3";
      4'd1: return "R4/R5/R11";
      4'd2: return "R7";
      4'd3: return "R8";
      default: return "R6";
    endcase
  endfunction

  task automatic drive(input logic [3:0] op, input logic [7:0] idx, input logic [7:0] data);
    case (op)
      4'd0: vblank_start = 1'b1;
      4'd1: begin crtc_we = 1'b1; crtc_idx = idx; crtc_wdata = data; end
      4'd2: begin ctl_we = 1'b1; ctl_wdata = data; end
      4'd3: begin clr_we = 1'b1; clr_wdata = data; end
      default: eng_done = data[2:0];
    endcase
  endtask

  task automatic idle_inputs();
    vblank_start = 1'b0; crtc_we = 1'b0; ctl_we = 1'b0; clr_we = 1'b0; eng_done = '0;
  endtask

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    tests++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    fails++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    check("R1 reset irq", {31'b0, irq}, 32'd0);
    check("R1 reset stat", {24'b0, stat}, 32'd0);
    check("R1 reset sense", {24'b0, sense_rd}, 32'd0);

    for (int i = 0; i < NV; i++) begin
      drive(VEC[i][31:28], VEC[i][27:20], VEC[i][19:12]);
      @(negedge clk);
      idle_inputs();
      check(tag_of(VEC[i][31:28]), {30'b0, irq, sense_rd[7]}, {30'b0, VEC[i][4], VEC[i][0]});
    end

    // R6 bit positions: all three pulses at once
    drive(4'd4, 8'h00, 8'h07);
    @(negedge clk); idle_inputs();
    check("R6 status bits", {24'b0, stat}, 32'h46);

    // R8 clear bit 1 only, then set wins over clear
    drive(4'd3, 8'h00, 8'h02);
    @(negedge clk); idle_inputs();
    check("R8 partial clear", {24'b0, stat}, 32'h44);
    clr_we = 1'b1; clr_wdata = 8'h44; eng_done = 3'b001;
    @(negedge clk); idle_inputs();
    check("R8 set wins", {24'b0, stat}, 32'h04);
    drive(4'd3, 8'h00, 8'hff);
    @(negedge clk); idle_inputs();
    check("R8 clear all", {24'b0, stat}, 32'h00);

    // R10 same-cycle write and vblank; tracker is pending here
    crtc_we = 1'b1; crtc_idx = 8'h11; crtc_wdata = 8'h00; vblank_start = 1'b1;
    @(negedge clk); idle_inputs();
    check("R10 disarm then pulse", {31'b0, sense_rd[7]}, 32'd0);
    crtc_we = 1'b1; crtc_idx = 8'h11; crtc_wdata = 8'h10; vblank_start = 1'b1;
    @(negedge clk); idle_inputs();
    check("R10 arm then pulse", {31'b0, sense_rd[7]}, 32'd1);

    // R9 registered timing: mask pending source off then on
    drive(4'd1, 8'h32, 8'h00);
    @(negedge clk); idle_inputs();
    check("R9 low after gate off", {31'b0, irq}, 32'd0);
    drive(4'd1, 8'h32, 8'h10);
    #1;
    check("R9 no change before edge", {31'b0, irq}, 32'd0);
    @(negedge clk); idle_inputs();
    check("R9 high after edge", {31'b0, irq}, 32'd1);
    drive(4'd4, 8'h00, 8'h04);
    @(negedge clk); idle_inputs();
    check("R9 engine keeps line", {31'b0, irq}, 32'd1);

    // R1 reset again from a busy state
    rst_n = 1'b0;
    @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    check("R1 re-reset", {23'b0, irq, stat, sense_rd}, 32'd0);
    drive(4'd1, 8'h32, 8'h10);
    @(negedge clk); idle_inputs();
    drive(4'd0, 8'h00, 8'h00);
    @(negedge clk); idle_inputs();
    check("R1 idle after reset", {30'b0, irq, sense_rd[7]}, 32'd3);

    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule